// File: doc/BRIEF.md
# Reconfigurable Pixel Transpose Buffer for an Edge Filter

This block sits between two interleaved 32-bit pixel memory banks and an external one-dimensional edge filter that takes eight samples at a time. It holds two neighbouring 4x4 blocks in an array of eight lanes, each four pixels deep. Per phase, the array shifts either downward, moving whole eight-sample vectors one depth step, or rightward, moving whole 32-bit words one lane step. Because of this, a single filter serves both edge directions, and the array also acts as the transpose store. A sequencer runs a fixed schedule for each block pair. It drives the bank enables and addresses and marks the end of the pair with a done pulse.

In row mode (mode 0) the edge runs vertically. The bank A word is the left block row and the bank B word is the right block row. Each row pair goes straight to the filter, the filtered rows collect in the array, and the array then writes them back to both banks. In column mode (mode 1) the edge runs horizontally and both blocks sit in one bank. A load/store phase shifts rightward. It brings in the eight rows of the new pair from the load bank and, in the same cycles, drains the previously filtered pair into the other bank. A ring phase then sends each four-sample-deep column through the filter and back into the array.

Top module: `tpb_transpose_buf`

## Requirements
- R1: After reset, busy, done and all four bank enables are 0.
- R2: A start pulse is accepted only while idle. Mode, load-bank select, store enable and both base addresses are captured at that moment. Start pulses or input changes during a sequence have no effect on the enables, addresses or sequence length.
- R3: Row mode, cycles 0 to 3 of the sequence: both banks are read at address rd_base+i. One cycle later the filter input carries bank B data in bits 63:32 and bank A data in bits 31:0. Sample s is byte s, with the low byte first.
- R4: Row mode, cycles 6 to 9: both banks are written at wr_base+j with the filtered row j. Bank A receives samples 0 to 3 and bank B receives samples 4 to 7. The filter output is taken one cycle after its input.
- R5: A row-mode sequence lasts 10 cycles, and done is high in cycle 9.
- R6: Column mode, cycles 0 to 7: only the load bank (select 0 gives A, 1 gives B) is read, at rd_base+k. Word k becomes sample k of every column.
- R7: Column mode, cycles 1 to 8, and only when the store enable is set: the other bank is written at wr_base+k-1 with word k of the previously filtered pair. With the store enable clear, no bank is written.
- R8: Column mode, cycles 9 to 12: the filter input carries column d = cycle-9. Byte s of that input is byte d of the loaded word s. Done is high in cycle 13, and the filtered columns are stored by the next column-mode sequence.
- R9: No bank is read and written in the same cycle.
- R10: Done is a one-cycle pulse, and busy falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a block-pair sequence when idle |
| mode_i | input | 1 | 0 row mode, 1 column mode |
| vsel_i | input | 1 | Column mode load bank: 0 A, 1 B |
| st_en_i | input | 1 | Column mode: store the previously filtered pair |
| rd_base_i | input | 5 | Base word address for loads |
| wr_base_i | input | 5 | Base word address for stores |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last cycle of a sequence |
| rd_en_a_o | output | 1 | Bank A read enable |
| wr_en_a_o | output | 1 | Bank A write enable |
| addr_a_o | output | 5 | Bank A word address |
| rd_data_a_i | input | 32 | Bank A read data, one cycle after rd_en |
| wr_data_a_o | output | 32 | Bank A write data |
| rd_en_b_o | output | 1 | Bank B read enable |
| wr_en_b_o | output | 1 | Bank B write enable |
| addr_b_o | output | 5 | Bank B word address |
| rd_data_b_i | input | 32 | Bank B read data, one cycle after rd_en |
| wr_data_b_o | output | 32 | Bank B write data |
| flt_in_o | output | 64 | Eight samples to the filter |
| flt_out_i | input | 64 | Filtered samples, one cycle later |

## Verification
The assertions check four things on every cycle: that no bank is read and written together, that a column-mode load touches only one bank, and that done and busy follow each other correctly. Only the bench's scenarios can show that the data is actually transposed. They check that filtered rows return to the right bank and address, that columns reach the filter in order, and that a stored pair matches the pair filtered one sequence earlier. The scenarios also show that a cleared store enable leaves memory untouched and that start pulses in mid-sequence are ignored.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  // Operating direction of a block-pair sequence.
  typedef enum logic {
    MODE_ROWS = 1'b0,  // edge between left and right block
    MODE_COLS = 1'b1   // edge between upper and lower block
  } tpb_mode_e;
endpackage

// File: rtl/tpb_seq.sv
module tpb_seq
  import tpb_pkg::*;
#(
  parameter int LANES = 8,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          vsel_i,
  input  logic          st_en_i,
  input  logic [AW-1:0] rd_base_i,
  input  logic [AW-1:0] wr_base_i,
  output logic          busy_o,
  output logic          done_o,
  output tpb_mode_e     mode_o,
  output logic          rt_sel_b_o,
  output logic          rd_a_o,
  output logic          rd_b_o,
  output logic          wr_a_o,
  output logic          wr_b_o,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic          sh_dn_o,
  output logic          sh_rt_o
);
  localparam int DEPTH  = LANES / 2;
  localparam int V_LAST = LANES + DEPTH + 1;
  localparam int CW     = $clog2(V_LAST + 1);
  localparam logic [CW-1:0] C_ONE   = CW'(1);
  localparam logic [CW-1:0] C_TWO   = CW'(2);
  localparam logic [CW-1:0] C_DEPTH = CW'(DEPTH);
  localparam logic [CW-1:0] C_LANES = CW'(LANES);
  localparam logic [CW-1:0] C_H_WR0 = CW'(DEPTH + 2);
  localparam logic [CW-1:0] C_H_END = CW'(2 * DEPTH + 1);
  localparam logic [CW-1:0] C_V_END = CW'(V_LAST);

  logic            run_q, run_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            take;
  tpb_mode_e       mode_q;
  logic            vsel_q, sten_q;
  logic [AW-1:0]   rbase_q, wbase_q;
  logic [CW-1:0]   last_cnt;

  assign last_cnt = (mode_q == MODE_COLS) ? C_V_END : C_H_END;
  assign take     = !run_q && start_i;

  // next state
  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!run_q) begin
      if (start_i) begin
        run_d = 1'b1;
        cnt_d = '0;
      end
    end else if (cnt_q == last_cnt) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + C_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // sequence parameters, captured only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_ROWS;
      vsel_q  <= 1'b0;
      sten_q  <= 1'b0;
      rbase_q <= '0;
      wbase_q <= '0;
    end else if (take) begin
      mode_q  <= tpb_mode_e'(mode_i);
      vsel_q  <= vsel_i;
      sten_q  <= st_en_i;
      rbase_q <= rd_base_i;
      wbase_q <= wr_base_i;
    end
  end

  // schedule decode
  logic [AW-1:0] ld_addr, st_addr;
  logic          ld, mv, st;

  always_comb begin
    rd_a_o   = 1'b0;
    rd_b_o   = 1'b0;
    wr_a_o   = 1'b0;
    wr_b_o   = 1'b0;
    sh_dn_o  = 1'b0;
    sh_rt_o  = 1'b0;
    ld       = 1'b0;
    mv       = 1'b0;
    st       = 1'b0;
    ld_addr  = rbase_q + AW'(cnt_q);
    st_addr  = wbase_q + AW'(cnt_q - C_ONE);
    addr_a_o = ld_addr;
    addr_b_o = ld_addr;
    if (run_q) begin
      if (mode_q == MODE_ROWS) begin
        ld      = cnt_q < C_DEPTH;
        st      = cnt_q >= C_H_WR0;
        rd_a_o  = ld;
        rd_b_o  = ld;
        wr_a_o  = st;
        wr_b_o  = st;
        sh_dn_o = cnt_q >= C_TWO;
        if (!ld) begin
          addr_a_o = wbase_q + AW'(cnt_q - C_H_WR0);
          addr_b_o = wbase_q + AW'(cnt_q - C_H_WR0);
        end
      end else begin
        ld      = cnt_q < C_LANES;
        mv      = (cnt_q >= C_ONE) && (cnt_q <= C_LANES);
        st      = mv && sten_q;
        sh_rt_o = mv;
        sh_dn_o = cnt_q > C_LANES;
        rd_a_o  = ld && !vsel_q;
        rd_b_o  = ld && vsel_q;
        wr_a_o  = st && vsel_q;
        wr_b_o  = st && !vsel_q;
        addr_a_o = vsel_q ? st_addr : ld_addr;
        addr_b_o = vsel_q ? ld_addr : st_addr;
      end
    end
  end

  assign busy_o     = run_q;
  assign done_o     = run_q && (cnt_q == last_cnt);
  assign mode_o     = mode_q;
  assign rt_sel_b_o = vsel_q;

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  a_r5_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
endmodule

// File: rtl/tpb_array.sv
module tpb_array #(
  parameter int LANES = 8,
  parameter int PIX_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sh_dn_i,
  input  logic [LANES*PIX_W-1:0]       dn_vec_i,
  input  logic                         sh_rt_i,
  input  logic [(LANES/2)*PIX_W-1:0]   rt_word_i,
  output logic [LANES*PIX_W-1:0]       head_vec_o,
  output logic [(LANES/2)*PIX_W-1:0]   head_word_o
);
  localparam int DEPTH = LANES / 2;

  // Cell (s,d): lane s (filter sample), depth d.
  // Downward: depth d takes depth d+1, the last depth takes the filter output.
  // Rightward: lane s takes lane s+1, the last lane takes the bank word.
  for (genvar s = 0; s < LANES; s++) begin : g_s
    for (genvar d = 0; d < DEPTH; d++) begin : g_d
      logic [PIX_W-1:0] q, dn_src, rt_src, nxt;
      logic             en;

      if (d == DEPTH - 1) begin : g_dn_edge
        assign dn_src = dn_vec_i[s*PIX_W +: PIX_W];
      end else begin : g_dn_in
        assign dn_src = g_s[s].g_d[d+1].q;
      end

      if (s == LANES - 1) begin : g_rt_edge
        assign rt_src = rt_word_i[d*PIX_W +: PIX_W];
      end else begin : g_rt_in
        assign rt_src = g_s[s+1].g_d[d].q;
      end

      assign en  = sh_dn_i || sh_rt_i;
      assign nxt = sh_dn_i ? dn_src : rt_src;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= nxt;
      end

      if (d == 0) begin : g_head_v
        assign head_vec_o[s*PIX_W +: PIX_W] = q;
      end
      if (s == 0) begin : g_head_w
        assign head_word_o[d*PIX_W +: PIX_W] = q;
      end
    end
  end
endmodule

// File: rtl/tpb_transpose_buf.sv
module tpb_transpose_buf
  import tpb_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PIX_W = 8,
  parameter int AW    = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           mode_i,
  input  logic                           vsel_i,
  input  logic                           st_en_i,
  input  logic [AW-1:0]                  rd_base_i,
  input  logic [AW-1:0]                  wr_base_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           rd_en_a_o,
  output logic                           wr_en_a_o,
  output logic [AW-1:0]                  addr_a_o,
  input  logic [(LANES/2)*PIX_W-1:0]     rd_data_a_i,
  output logic [(LANES/2)*PIX_W-1:0]     wr_data_a_o,
  output logic                           rd_en_b_o,
  output logic                           wr_en_b_o,
  output logic [AW-1:0]                  addr_b_o,
  input  logic [(LANES/2)*PIX_W-1:0]     rd_data_b_i,
  output logic [(LANES/2)*PIX_W-1:0]     wr_data_b_o,
  output logic [LANES*PIX_W-1:0]         flt_in_o,
  input  logic [LANES*PIX_W-1:0]         flt_out_i
);
  localparam int WORD_W = (LANES / 2) * PIX_W;
  localparam int VEC_W  = LANES * PIX_W;

  tpb_mode_e          mode_q;
  logic               rt_sel_b, sh_dn, sh_rt;
  logic [VEC_W-1:0]   head_vec;
  logic [WORD_W-1:0]  head_word, rt_word;

  tpb_seq #(.LANES(LANES), .AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .vsel_i     (vsel_i),
    .st_en_i    (st_en_i),
    .rd_base_i  (rd_base_i),
    .wr_base_i  (wr_base_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mode_o     (mode_q),
    .rt_sel_b_o (rt_sel_b),
    .rd_a_o     (rd_en_a_o),
    .rd_b_o     (rd_en_b_o),
    .wr_a_o     (wr_en_a_o),
    .wr_b_o     (wr_en_b_o),
    .addr_a_o   (addr_a_o),
    .addr_b_o   (addr_b_o),
    .sh_dn_o    (sh_dn),
    .sh_rt_o    (sh_rt)
  );

  assign rt_word = rt_sel_b ? rd_data_b_i : rd_data_a_i;

  tpb_array #(.LANES(LANES), .PIX_W(PIX_W)) u_arr (
    .clk         (clk),
    .rst_n       (rst_n),
    .sh_dn_i     (sh_dn),
    .dn_vec_i    (flt_out_i),
    .sh_rt_i     (sh_rt),
    .rt_word_i   (rt_word),
    .head_vec_o  (head_vec),
    .head_word_o (head_word)
  );

  // Row mode feeds the filter straight from the banks; column mode from the array.
  assign flt_in_o    = (mode_q == MODE_COLS) ? head_vec : {rd_data_b_i, rd_data_a_i};
  assign wr_data_a_o = (mode_q == MODE_COLS) ? head_word : head_vec[WORD_W-1:0];
  assign wr_data_b_o = (mode_q == MODE_COLS) ? head_word : head_vec[VEC_W-1:WORD_W];

  a_r9_bank_a_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_a_o && wr_en_a_o));
  a_r9_bank_b_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_b_o && wr_en_b_o));
  a_r6_one_load_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == MODE_COLS) |-> !(rd_en_a_o && rd_en_b_o));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(rd_en_a_o || rd_en_b_o || wr_en_a_o || wr_en_b_o));
endmodule

// File: tb/tb_tpb_transpose_buf.sv
module tb_tpb_transpose_buf;
  logic        clk = 1'b0;
  logic        rst_n, start, mode, vsel, st_en;
  logic [4:0]  rd_base, wr_base;
  logic        busy, done, rd_en_a, wr_en_a, rd_en_b, wr_en_b;
  logic [4:0]  addr_a, addr_b;
  logic [31:0] rd_data_a, rd_data_b, wr_data_a, wr_data_b;
  logic [63:0] flt_in, flt_out;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem_a [32];
  logic [31:0] mem_b [32];
  logic [31:0] a0 [32];
  logic [31:0] b0 [32];

  always #4 clk = ~clk;

  tpb_transpose_buf dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .vsel_i(vsel),
    .st_en_i(st_en), .rd_base_i(rd_base), .wr_base_i(wr_base),
    .busy_o(busy), .done_o(done),
    .rd_en_a_o(rd_en_a), .wr_en_a_o(wr_en_a), .addr_a_o(addr_a),
    .rd_data_a_i(rd_data_a), .wr_data_a_o(wr_data_a),
    .rd_en_b_o(rd_en_b), .wr_en_b_o(wr_en_b), .addr_b_o(addr_b),
    .rd_data_b_i(rd_data_b), .wr_data_b_o(wr_data_b),
    .flt_in_o(flt_in), .flt_out_i(flt_out)
  );

  // external stand-ins: two banks and a filter that adds s+1 to sample s
  function automatic logic [63:0] filt(input logic [63:0] v);
    logic [63:0] r;
    for (int s = 0; s < 8; s++) r[s*8 +: 8] = v[s*8 +: 8] + 8'(s + 1);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rd_en_a) rd_data_a <= mem_a[addr_a];
    if (wr_en_a) mem_a[addr_a] <= wr_data_a;
    if (rd_en_b) rd_data_b <= mem_b[addr_b];
    if (wr_en_b) mem_b[addr_b] <= wr_data_b;
    flt_out <= filt(flt_in);
  end

  // behavioural reference: cycle index within the current sequence
  int t = -1;
  bit m_cols, m_vsel, m_sten;
  int m_rb, m_wb;
  always @(posedge clk) begin
    if (!rst_n) t = -1;
    else if (t < 0) begin
      if (start) begin
        t = 0; m_cols = mode; m_vsel = vsel; m_sten = st_en;
        m_rb = int'(rd_base); m_wb = int'(wr_base);
      end
    end else if (t == (m_cols ? 13 : 9)) t = -1;
    else t++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", req, act, exp, t);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit era, erb, ewa, ewb, edone;
      int ea, eb;
      logic [63:0] ef;
      era = 0; erb = 0; ewa = 0; ewb = 0; edone = 0; ea = 0; eb = 0;
      if (t >= 0 && !m_cols) begin
        era = t < 4; erb = era;
        ewa = t >= 6; ewb = ewa;
        ea = era ? m_rb + t : m_wb + t - 6; eb = ea;
        edone = (t == 9);
      end else if (t >= 0) begin
        era = (t < 8) && !m_vsel; erb = (t < 8) && m_vsel;
        ewa = m_sten && t >= 1 && t <= 8 && m_vsel;
        ewb = m_sten && t >= 1 && t <= 8 && !m_vsel;
        if (m_vsel) begin ea = m_wb + t - 1; eb = m_rb + t; end
        else        begin ea = m_rb + t;     eb = m_wb + t - 1; end
        edone = (t == 13);
      end
      chk(busy == (t >= 0), "R2 busy span", 64'(busy), 64'(t >= 0));
      chk(done == edone, m_cols ? "R8 done cycle" : "R5 done cycle", 64'(done), 64'(edone));
      chk({rd_en_a, rd_en_b} == {era, erb}, m_cols ? "R6 load enables" : "R3 read enables",
          64'({rd_en_a, rd_en_b}), 64'({era, erb}));
      chk({wr_en_a, wr_en_b} == {ewa, ewb}, m_cols ? "R7 store enables" : "R4 write enables",
          64'({wr_en_a, wr_en_b}), 64'({ewa, ewb}));
      if (era || ewa) chk(addr_a == 5'(ea), "R2 bank A address", 64'(addr_a), 64'(5'(ea)));
      if (erb || ewb) chk(addr_b == 5'(eb), "R2 bank B address", 64'(addr_b), 64'(5'(eb)));
      if (t >= 1 && t <= 4 && !m_cols) begin
        ef = {b0[m_rb + t - 1], a0[m_rb + t - 1]};
        chk(flt_in == ef, "R3 filter input row", flt_in, ef);
      end
      if (t >= 9 && t <= 12 && m_cols) begin
        for (int s = 0; s < 8; s++)
          ef[s*8 +: 8] = m_vsel ? b0[m_rb + s][(t-9)*8 +: 8] : a0[m_rb + s][(t-9)*8 +: 8];
        chk(flt_in == ef, "R8 filter input column", flt_in, ef);
      end
    end
  end

  task automatic run_seq(input bit md, input bit vs, input bit se, input int rb,
                         input int wb, input int poke);
    @(negedge clk);
    mode = md; vsel = vs; st_en = se; rd_base = 5'(rb); wr_base = 5'(wb); start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode = !md; vsel = !vs; st_en = !se; rd_base = 5'(rb + 3); wr_base = 5'(wb + 5);
    for (int i = 1; i < 17; i++) begin
      start = (i == poke);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  function automatic logic [31:0] addb(input logic [31:0] w, input int k0, input bit per_byte);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = w[b*8 +: 8] + 8'(per_byte ? b + k0 : k0);
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) begin
      a0[i] = {8'(i*16+7), 8'(i*16+5), 8'(i*16+3), 8'(i*16+1)};
      b0[i] = {8'(i*9+200), 8'(i*9+150), 8'(i*9+100), 8'(i*9+50)};
      mem_a[i] = a0[i]; mem_b[i] = b0[i];
    end
    rd_data_a = '0; rd_data_b = '0; flt_out = '0;
    start = 0; mode = 0; vsel = 0; st_en = 0; rd_base = '0; wr_base = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done at reset", 64'({busy, done}), 64'(0));
    chk({rd_en_a, wr_en_a, rd_en_b, wr_en_b} == 4'b0, "R1 enables at reset",
        64'({rd_en_a, wr_en_a, rd_en_b, wr_en_b}), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // row mode with an ignored start in mid-sequence (R2)
    run_seq(1'b0, 1'b0, 1'b0, 0, 8, 3);
    for (int j = 0; j < 4; j++) begin
      chk(mem_a[8+j] == addb(a0[j], 1, 1), "R4 bank A filtered row", 64'(mem_a[8+j]), 64'(addb(a0[j], 1, 1)));
      chk(mem_b[8+j] == addb(b0[j], 5, 1), "R4 bank B filtered row", 64'(mem_b[8+j]), 64'(addb(b0[j], 5, 1)));
    end
    // column mode from bank A, store disabled (R7 gating)
    run_seq(1'b1, 1'b0, 1'b0, 0, 16, 6);
    for (int k = 16; k < 24; k++)
      chk(mem_b[k] == b0[k], "R7 no store when disabled", 64'(mem_b[k]), 64'(b0[k]));
    // column mode from bank B, storing the bank A pair
    run_seq(1'b1, 1'b1, 1'b1, 0, 16, 11);
    for (int k = 0; k < 8; k++)
      chk(mem_a[16+k] == addb(a0[k], k + 1, 0), "R7 stored filtered pair", 64'(mem_a[16+k]), 64'(addb(a0[k], k + 1, 0)));
    // flush the bank B pair
    run_seq(1'b1, 1'b0, 1'b1, 0, 24, 0);
    for (int k = 0; k < 8; k++)
      chk(mem_b[24+k] == addb(b0[k], k + 1, 0), "R8 filtered columns", 64'(mem_b[24+k]), 64'(addb(b0[k], k + 1, 0)));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule